// File: doc/BRIEF.md
# Prioritised External Interrupt Controller

This block gathers interrupt requests from up to 31 peripheral sources and drives a single external-interrupt line toward one processor context. Every source owns a small priority register, a pending bit and an enable bit. A shared threshold register sets the lowest priority that is allowed to interrupt. The output is raised whenever at least one source is pending, enabled and has a priority strictly above the threshold. Among such sources, the highest priority wins. A tie goes to the smaller source number.

Software runs a claim/complete handshake through one register. A read of that register returns the number of the winning source and takes that source out of contention. A later write of the same number hands the source back. Source number 0 is reserved and means "nothing to service". Requests are level signals from other clock domains. They are synchronised before they set a pending bit. All registers are reached over a single-cycle word bus whose read data is combinational.

Top module: `irq_hub`

## Requirements
- R1: While reset is active and afterwards until software writes, every priority, enable, pending and threshold field reads 0, `irq_o` is low and a claim read returns 0.
- R2: The priority of source k sits at byte address 4·k in bits [2:0], and the upper bits read 0. Address 0x0000 always reads 0, and writes to it are ignored.
- R3: A request held high on `src_req_i[k]` sets bit k of the pending word at 0x1000 no later than the third rising clock edge. Bit 0 reads 0. Writes to the pending word have no effect.
- R4: A source whose priority is 0 never makes `irq_o` high and is never returned by a claim read.
- R5: A pending source takes part only if bit k of the enable word at 0x2000 is set and its priority is strictly greater than the threshold held in bits [2:0] at 0x3000. A priority equal to the threshold does not take part. Enable bit 0 reads 0.
- R6: A claim read returns the participating source with the largest priority. Among equal priorities, it returns the smallest source number.
- R7: `irq_o` is high exactly when some source takes part under R4 and R5. It follows any register change in the cycle after the write edge.
- R8: A read of 0x3004 returns the winning source number, or 0 if none takes part. A nonzero result clears that pending bit and marks the source in service. A source in service does not become pending again while its request stays high.
- R9: A write of k to 0x3004 while k is in service releases it, and a request still held high then sets pending again. A written number that is not in service changes nothing.
- R10: When a claim read and the arrival of a synchronised request from another source fall on the same edge, the claimed source is cleared and the new source becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req_i | input | 31 | Level requests, bit k-1 belongs to source k |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 14 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | External interrupt toward the processor |

## Verification
The claim read and the latching of a new synchronised request can land on the same clock edge. One of them clears a pending bit and the other sets a different one. The bench raises the second request exactly two edges before a claim read, so that its synchronised copy arrives on the claim edge. It then checks three things: the claim returned the older source, the pending word shows only the new source, and the next claim returns the new one. Completion and a still-high request are also set against each other. The bench checks that a bogus completion leaves every source blocked, and that a real completion lets the held request pend again.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [13:0] PEND_OFS  = 14'h1000;
  localparam logic [13:0] EN_OFS    = 14'h2000;
  localparam logic [13:0] THR_OFS   = 14'h3000;
  localparam logic [13:0] CLAIM_OFS = 14'h3004;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int unsigned W      = 31,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  for (genvar k = 0; k < STAGES; k++) begin : g_stg
    if (k == 0) begin : g_first
      assign stg_d[k] = d_i;
    end else begin : g_next
      assign stg_d[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ID_W   = 5
) (
  input  logic [N_SRC:0]             pend_i,
  input  logic [N_SRC:0]             en_i,
  input  logic [N_SRC:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]          thr_i,
  output logic [ID_W-1:0]            win_id_o
);
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;

  // Scan upward; strict compare keeps the earlier (smaller) ID on ties.
  // Starting the bar at the threshold folds the threshold test in.
  always_comb begin
    best_p  = thr_i;
    best_id = '0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
        best_p  = prio_i[i];
        best_id = ID_W'(i);
      end
    end
  end

  assign win_id_o = best_id;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_req_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned ID_W    = $clog2(N_SRC + 1);
  localparam int unsigned PRIO_SZ = 4 * (N_SRC + 1);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {rst_n, rs1_q} <= 2'b00;
    else         {rst_n, rs1_q} <= {rs1_q, 1'b1};
  end

  logic [N_SRC-1:0] req_s;
  logic [N_SRC:0]   req_v;
  irq_hub_sync #(.W(N_SRC), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (src_req_i),
    .q_o   (req_s)
  );
  assign req_v = {req_s, 1'b0};

  logic [N_SRC:0][PRIO_W-1:0] prio_q;
  logic [N_SRC:0]             pend_q, pend_d;
  logic [N_SRC:0]             isv_q, isv_d;
  logic [N_SRC:0]             en_q;
  logic [PRIO_W-1:0]          thr_q;
  logic [ID_W-1:0]            win_id;

  irq_hub_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .pend_i  (pend_q),
    .en_i    (en_q),
    .prio_i  (prio_q),
    .thr_i   (thr_q),
    .win_id_o(win_id)
  );
  assign irq_o = (win_id != '0);

  // address decode
  region_e         rg;
  logic [ID_W-1:0] prio_idx;
  logic            acc_rd, acc_wr;
  assign acc_rd   = bus_sel_i & ~bus_wr_i;
  assign acc_wr   = bus_sel_i & bus_wr_i;
  assign prio_idx = bus_addr_i[ID_W+1:2];

  always_comb begin
    rg = RG_NONE;
    if (bus_addr_i[1:0] == 2'b00) begin
      if (bus_addr_i < ADDR_W'(PRIO_SZ))          rg = RG_PRIO;
      else if (bus_addr_i == ADDR_W'(PEND_OFS))   rg = RG_PEND;
      else if (bus_addr_i == ADDR_W'(EN_OFS))     rg = RG_EN;
      else if (bus_addr_i == ADDR_W'(THR_OFS))    rg = RG_THR;
      else if (bus_addr_i == ADDR_W'(CLAIM_OFS))  rg = RG_CLAIM;
    end
  end

  always_comb begin
    case (rg)
      RG_PRIO:  bus_rdata_o = 32'(prio_q[prio_idx]);
      RG_PEND:  bus_rdata_o = 32'(pend_q);
      RG_EN:    bus_rdata_o = 32'(en_q);
      RG_THR:   bus_rdata_o = 32'(thr_q);
      RG_CLAIM: bus_rdata_o = 32'(win_id);
      default:  bus_rdata_o = '0;
    endcase
  end

  // claim / complete handshake
  logic            claim_ev, done_ev, done_ok;
  logic [ID_W-1:0] done_id;
  logic            prio_we, en_we, thr_we;

  assign claim_ev = acc_rd && (rg == RG_CLAIM) && (win_id != '0);
  assign done_ev  = acc_wr && (rg == RG_CLAIM);
  assign done_id  = bus_wdata_i[ID_W-1:0];
  assign done_ok  = (bus_wdata_i[31:ID_W] == '0) && (32'(done_id) <= N_SRC)
                    && isv_q[done_id];
  assign prio_we  = acc_wr && (rg == RG_PRIO) && (prio_idx != '0);
  assign en_we    = acc_wr && (rg == RG_EN);
  assign thr_we   = acc_wr && (rg == RG_THR);

  always_comb begin
    isv_d  = isv_q;
    pend_d = pend_q | (req_v & ~isv_q);
    if (done_ev && done_ok) isv_d[done_id] = 1'b0;
    if (claim_ev) begin
      pend_d[win_id] = 1'b0;
      isv_d[win_id]  = 1'b1;
    end
    pend_d[0] = 1'b0;
    isv_d[0]  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
      pend_q <= '0;
      isv_q  <= '0;
    end else begin
      if (prio_we) prio_q[prio_idx] <= bus_wdata_i[PRIO_W-1:0];
      if (en_we)   en_q             <= {bus_wdata_i[N_SRC:1], 1'b0};
      if (thr_we)  thr_q            <= bus_wdata_i[PRIO_W-1:0];
      pend_q <= pend_d;
      isv_q  <= isv_d;
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_SRC  = 31,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned ID_W   = 5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_sel_i,
  input logic                       bus_wr_i,
  input logic [ADDR_W-1:0]          bus_addr_i,
  input logic [31:0]                bus_rdata_o,
  input logic                       irq_o,
  input logic [N_SRC:0]             pend_q,
  input logic [N_SRC:0]             isv_q,
  input logic [N_SRC:0][PRIO_W-1:0] prio_q,
  input logic [PRIO_W-1:0]          thr_q,
  input logic [ID_W-1:0]            win_id
);
  logic claim_rd, claim_wr;
  assign claim_rd = bus_sel_i && !bus_wr_i && (bus_addr_i == ADDR_W'(CLAIM_OFS));
  assign claim_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(CLAIM_OFS));

  p_addr0_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_wr_i && bus_addr_i == '0) |-> (bus_rdata_o == '0));

  p_no_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !claim_rd |=> (($past(pend_q) & ~pend_q) == '0));

  p_above_thr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (prio_q[win_id] > thr_q));

  p_claim_vs_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rd |-> ((bus_rdata_o != '0) == irq_o));

  p_claim_takes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_rd && irq_o) |=> (!pend_q[$past(win_id)] && isv_q[$past(win_id)]));

  p_busy_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & isv_q) == '0));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !claim_wr |=> (($past(isv_q) & ~isv_q) == '0));
endmodule

bind irq_hub irq_hub_chk #(
  .N_SRC (N_SRC),
  .PRIO_W(PRIO_W),
  .ADDR_W(ADDR_W),
  .ID_W  (ID_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n),
  .bus_sel_i  (bus_sel_i),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .pend_q     (pend_q),
  .isv_q      (isv_q),
  .prio_q     (prio_q),
  .thr_q      (thr_q),
  .win_id     (win_id)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  localparam logic [13:0] A_PEND  = 14'h1000;
  localparam logic [13:0] A_EN    = 14'h2000;
  localparam logic [13:0] A_THR   = 14'h3000;
  localparam logic [13:0] A_CLAIM = 14'h3004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] req = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(req),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [13:0] pa(input int k);
    return 14'(4 * k);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq after reset", 32'(irq), 0);
    bus_rd(A_CLAIM, d); chk("R1 claim after reset", d, 0);
    bus_rd(A_PEND, d);  chk("R1 pending after reset", d, 0);
    bus_rd(A_EN, d);    chk("R1 enable after reset", d, 0);
    bus_rd(A_THR, d);   chk("R1 threshold after reset", d, 0);
    bus_rd(pa(5), d);   chk("R1 priority 5 after reset", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_wr(pa(3), 32'hFFFF_FFFF);
    bus_rd(pa(3), d); chk("R2 priority field width", d, 32'h7);
    bus_wr(pa(0), 32'h5);
    bus_rd(pa(0), d); chk("R2 reserved address 0", d, 0);
    bus_wr(A_EN, 32'hFFFF_FFFF);
    bus_rd(A_EN, d);  chk("R5 enable bit 0 reads 0", d, 32'hFFFF_FFFE);
    bus_wr(A_THR, 32'hF);
    bus_rd(A_THR, d); chk("R5 threshold field width", d, 32'h7);
    bus_wr(A_EN, 0); bus_wr(A_THR, 0); bus_wr(pa(3), 0);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    req[3] = 1'b1;                       // source 4
    wait_cyc(3);
    bus_rd(A_PEND, d); chk("R3 pending latched", d, 32'h10);
    chk("R5 disabled source no irq", 32'(irq), 0);
    bus_wr(A_PEND, 32'h0);
    bus_rd(A_PEND, d); chk("R3 pending write ignored", d, 32'h10);
    bus_wr(A_EN, 32'h10);
    chk("R4 priority 0 no irq", 32'(irq), 0);
    bus_rd(A_CLAIM, d); chk("R4 priority 0 not claimed", d, 0);
    bus_wr(pa(4), 2);
    chk("R7 irq follows priority write", 32'(irq), 1);
    bus_wr(A_THR, 2);
    chk("R5 equal threshold blocks", 32'(irq), 0);
    bus_wr(A_THR, 1);
    chk("R5 above threshold fires", 32'(irq), 1);
  endtask

  task automatic t_select;
    logic [31:0] d;
    bus_wr(pa(7), 3); bus_wr(pa(9), 5); bus_wr(pa(12), 5);
    bus_wr(A_EN, 32'hFFFF_FFFE); bus_wr(A_THR, 0);
    req[6] = 1'b1; req[8] = 1'b1; req[11] = 1'b1;
    wait_cyc(3);
    bus_rd(A_CLAIM, d); chk("R6 tie picks smaller id", d, 9);
    bus_rd(A_CLAIM, d); chk("R6 second of tie", d, 12);
    bus_rd(A_CLAIM, d); chk("R6 next priority", d, 7);
    bus_rd(A_CLAIM, d); chk("R6 lowest priority", d, 4);
    bus_rd(A_CLAIM, d); chk("R8 nothing left claims 0", d, 0);
    chk("R7 irq low when all in service", 32'(irq), 0);
    wait_cyc(3);
    bus_rd(A_PEND, d); chk("R8 in service not re-pended", d, 0);
  endtask

  task automatic t_complete;
    logic [31:0] d;
    bus_wr(A_CLAIM, 20);
    wait_cyc(3);
    bus_rd(A_PEND, d); chk("R9 bogus completion ignored", d, 0);
    bus_wr(A_CLAIM, 9);
    wait_cyc(3);
    bus_rd(A_PEND, d); chk("R9 release re-pends held request", d, 32'h200);
    chk("R7 irq after release", 32'(irq), 1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    bus_wr(pa(15), 1);
    req[14] = 1'b1;                      // source 15, lands on claim edge
    @(negedge clk);
    bus_rd(A_CLAIM, d); chk("R10 claim returns older source", d, 9);
    bus_rd(A_PEND, d);  chk("R10 claimed cleared, new latched", d, 32'h8000);
    bus_rd(A_CLAIM, d); chk("R10 new source claimed next", d, 15);
    bus_rd(A_CLAIM, d); chk("R8 empty after both", d, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset;
    t_regs;
    t_pending;
    t_select;
    t_complete;
    t_same_cycle;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule